// File: doc/BRIEF.md
# Post-Configuration Reset Initialization Sequencer

This block brings a freshly configured logic region out of reset in a fixed order. From the moment configuration begins it holds a target reset line asserted. Once the configuration-complete input goes high, it reads an initialization profile from a small word-addressed memory. It waits a programmable number of microseconds, then loads a bank of wire words. Next it plays out a list of address/data register writes while reset is still held. After a second delay it releases reset. After a third delay it issues a list of address/mask trigger writes, and it finishes by raising a completion flag.

The profile memory is read through a combinational port: the block drives a word address and samples the returned word in the same cycle. A free-running prescaler of `CLKS_PER_US` clock cycles forms the microsecond unit for all three delays. Register and trigger writes each leave through a valid/ready port, with at most one transfer outstanding at a time. A profile whose leading magic word does not match skips every step and simply releases reset.

Top module: `cfg_init_seq`

## Requirements
- R1: While `rst_n` is low, and at the clock edge after any cycle in which `cfg_start_i` is high, `tgt_rst_o` is 1, every wire word is 0, both valid outputs are 0 and `seq_done_o` is 0. `cfg_start_i` takes priority over every other input.
- R2: If profile word 0 differs from `MAGIC`, then at the second clock edge that samples `cfg_done_i` high in the idle state, `tgt_rst_o` drops to 0 and `seq_done_o` rises. No wire word, register write or trigger write is produced.
- R3: With a valid magic word, let edge 0 be the first edge that samples `cfg_done_i` high. Wire word j takes its profile value at edge 8 + W·`CLKS_PER_US` + j, where W is the done-wait. Each word is written exactly once.
- R4: Profile layout by word address: 0 magic, 1 done-wait (µs), 2 register-wait (µs), 3 reset-wait (µs), 4 register count, 5 trigger count, 8+j wire word j. Register entry i sits at RB+2i (address) and RB+2i+1 (data), with RB = 8+`NUM_WIRES`. Trigger entry i sits at TB+2i (address) and TB+2i+1 (mask), with TB = RB+2·`MAX_REGS`.
- R5: Register entries are issued in index order while `tgt_rst_o` is 1. An entry's valid rises two edges after the edge that finished the previous step (the last wire write or the previous handshake).
- R6: `tgt_rst_o` falls at the (R·`CLKS_PER_US`+1)-th edge after the edge that finished the register step, where R is the register-wait.
- R7: The first trigger valid rises at the (S·`CLKS_PER_US`+3)-th edge after the edge that released reset, where S is the reset-wait. Triggers are issued in index order, only while reset is released.
- R8: A register count of zero skips the register step, so the register-wait starts at the edge of the last wire write. A trigger count of zero skips the trigger step.
- R9: A count larger than `MAX_REGS` (for registers) or `MAX_TRIGS` (for triggers) is treated as that maximum.
- R10: `seq_done_o` rises at the edge of the last trigger handshake, or at the end of the reset-wait when there are no triggers. It stays high with reset released until `cfg_start_i`.
- R11: A valid output stays 1 with its address and data/mask unchanged until the ready input is sampled high. It falls at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_i | input | 1 | Configuration is beginning; restarts the sequencer |
| cfg_done_i | input | 1 | Configuration complete (level) |
| prof_addr_o | output | PA_W | Profile memory word address |
| prof_data_i | input | 32 | Profile memory read data, same cycle |
| tgt_rst_o | output | 1 | Reset to the initialized logic, active high |
| wire_o | output | 32·NUM_WIRES | Wire words, word j in bits 32j+31:32j |
| reg_valid_o | output | 1 | Register write pending |
| reg_ready_i | input | 1 | Register write accepted |
| reg_addr_o | output | 32 | Register write address |
| reg_data_o | output | 32 | Register write data |
| trig_valid_o | output | 1 | Trigger write pending |
| trig_ready_i | input | 1 | Trigger write accepted |
| trig_addr_o | output | 32 | Trigger address |
| trig_mask_o | output | 32 | Trigger mask |
| seq_done_o | output | 1 | Sequence complete |

## Verification
Every output is registered, so each result is due at a fixed count of edges after its cause. The header takes six edges after done is seen. Each delay spans its microsecond count times the prescaler plus one edge. A wire word appears one edge after the previous one. A valid rises two edges after the step before it, and it falls at the very edge where ready is sampled high. The bench walks the same schedule as a sequential script that advances one clock edge per step. It reads the ready inputs exactly as the design samples them at that edge, and it compares every output half a cycle later, so valid/ready stalls of any length keep the model aligned.

// File: rtl/cfg_init_pkg.sv
package cfg_init_pkg;

    // Header word offsets inside the profile memory
    localparam int unsigned HDR_MAGIC = 0;
    localparam int unsigned HDR_DWAIT = 1;
    localparam int unsigned HDR_RWAIT = 2;
    localparam int unsigned HDR_SWAIT = 3;
    localparam int unsigned HDR_RCNT  = 4;
    localparam int unsigned HDR_TCNT  = 5;
    localparam int unsigned WIRE_BASE = 8;

    localparam logic [31:0] DEFAULT_MAGIC = 32'h5A17_C0DE;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR,
        S_DLY_DONE,
        S_WIRE,
        S_REG_A,
        S_REG_D,
        S_REG_W,
        S_DLY_REG,
        S_DLY_RST,
        S_TRG_A,
        S_TRG_D,
        S_TRG_W,
        S_FIN
    } seq_state_e;

endpackage

// File: rtl/cfg_init_delay.sv
module cfg_init_delay #(
    parameter int unsigned CLKS_PER_US = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [31:0] us_i,
    output logic        expired_o
);
    localparam int unsigned PRE_W = $clog2(CLKS_PER_US + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

    typedef struct packed {
        logic [31:0]      us;
        logic [PRE_W-1:0] pre;
    } dly_t;

    dly_t dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        if (load_i) begin
            dly_d.us  = us_i;
            dly_d.pre = '0;
        end else if (dly_q.us != 32'd0) begin
            if (dly_q.pre == PRE_LAST) begin
                dly_d.pre = '0;
                dly_d.us  = dly_q.us - 32'd1;
            end else begin
                dly_d.pre = dly_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
    end

    assign expired_o = (dly_q.us == 32'd0);

    // R3/R6/R7: a freshly loaded zero delay is expired at once, a nonzero one is not
    p_load_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (expired_o == ($past(us_i) == 32'd0)));

    // R6: the microsecond count never rises unless reloaded
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (dly_q.us <= $past(dly_q.us)));

endmodule

// File: rtl/cfg_init_wire_bank.sv
module cfg_init_wire_bank #(
    parameter int unsigned NUM_WIRES = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      we_i,
    input  logic [$clog2(NUM_WIRES)-1:0] idx_i,
    input  logic [31:0]               data_i,
    output logic [32*NUM_WIRES-1:0]   wire_o
);
    localparam int unsigned WI_W = $clog2(NUM_WIRES);

    for (genvar g = 0; g < NUM_WIRES; g++) begin : g_word
        logic [31:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (clr_i)
                word_d = '0;
            else if (we_i && (idx_i == WI_W'(g)))
                word_d = data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign wire_o[32*g +: 32] = word_q;
    end

    // R1: a clear request empties the whole bank at the next edge
    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (wire_o == '0));

endmodule

// File: rtl/cfg_init_seq.sv
module cfg_init_seq
    import cfg_init_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 100,
    parameter int unsigned NUM_WIRES   = 32,
    parameter int unsigned MAX_REGS    = 256,
    parameter int unsigned MAX_TRIGS   = 32,
    parameter logic [31:0] MAGIC       = DEFAULT_MAGIC,
    localparam int unsigned REG_BASE   = WIRE_BASE + NUM_WIRES,
    localparam int unsigned TRIG_BASE  = REG_BASE + 2 * MAX_REGS,
    localparam int unsigned DEPTH      = TRIG_BASE + 2 * MAX_TRIGS,
    localparam int unsigned PA_W       = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_start_i,
    input  logic                    cfg_done_i,
    output logic [PA_W-1:0]         prof_addr_o,
    input  logic [31:0]             prof_data_i,
    output logic                    tgt_rst_o,
    output logic [32*NUM_WIRES-1:0] wire_o,
    output logic                    reg_valid_o,
    input  logic                    reg_ready_i,
    output logic [31:0]             reg_addr_o,
    output logic [31:0]             reg_data_o,
    output logic                    trig_valid_o,
    input  logic                    trig_ready_i,
    output logic [31:0]             trig_addr_o,
    output logic [31:0]             trig_mask_o,
    output logic                    seq_done_o
);
    localparam int unsigned CR_W    = $clog2(MAX_REGS + 1);
    localparam int unsigned CT_W    = $clog2(MAX_TRIGS + 1);
    localparam int unsigned WI_W    = $clog2(NUM_WIRES);
    localparam int unsigned BIG_A   = (NUM_WIRES > MAX_REGS) ? NUM_WIRES : MAX_REGS;
    localparam int unsigned BIG_B   = (BIG_A > MAX_TRIGS) ? BIG_A : MAX_TRIGS;
    localparam int unsigned IDX_RAW = $clog2(BIG_B + 1);
    localparam int unsigned IDX_W   = (IDX_RAW < 3) ? 3 : IDX_RAW;

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [31:0]      dwait;
        logic [31:0]      rwait;
        logic [31:0]      swait;
        logic [CR_W-1:0]  rcnt;
        logic [CT_W-1:0]  tcnt;
        logic             rst;
        logic             done;
        logic             rv;
        logic [31:0]      ra;
        logic [31:0]      rd;
        logic             tv;
        logic [31:0]      ta;
        logic [31:0]      tm;
    } seq_t;

    seq_t             st_d, st_q;
    logic             wire_we, wire_clr, dly_load, dly_exp;
    logic [31:0]      dly_val;
    logic [PA_W-1:0]  addr_c;
    logic [IDX_W-1:0] idx_inc;
    logic             last_wire, last_reg, last_trg;

    assign idx_inc   = st_q.idx + 1'b1;
    assign last_wire = (st_q.idx == IDX_W'(NUM_WIRES - 1));
    assign last_reg  = (idx_inc == IDX_W'(st_q.rcnt));
    assign last_trg  = (idx_inc == IDX_W'(st_q.tcnt));

    cfg_init_delay #(
        .CLKS_PER_US(CLKS_PER_US)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (dly_load),
        .us_i      (dly_val),
        .expired_o (dly_exp)
    );

    cfg_init_wire_bank #(
        .NUM_WIRES(NUM_WIRES)
    ) u_wires (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (wire_clr),
        .we_i   (wire_we),
        .idx_i  (st_q.idx[WI_W-1:0]),
        .data_i (prof_data_i),
        .wire_o (wire_o)
    );

    always_comb begin
        st_d     = st_q;
        wire_we  = 1'b0;
        wire_clr = 1'b0;
        dly_load = 1'b0;
        dly_val  = st_q.dwait;
        addr_c   = '0;

        case (st_q.state)
            S_IDLE: begin
                if (cfg_done_i) begin
                    st_d.state = S_HDR;
                    st_d.idx   = '0;
                end
            end
            S_HDR: begin
                addr_c   = PA_W'(st_q.idx);
                st_d.idx = idx_inc;
                if (st_q.idx == IDX_W'(HDR_MAGIC)) begin
                    if (prof_data_i != MAGIC) begin
                        st_d.state = S_FIN;
                        st_d.rst   = 1'b0;
                        st_d.done  = 1'b1;
                    end
                end else if (st_q.idx == IDX_W'(HDR_DWAIT)) begin
                    st_d.dwait = prof_data_i;
                end else if (st_q.idx == IDX_W'(HDR_RWAIT)) begin
                    st_d.rwait = prof_data_i;
                end else if (st_q.idx == IDX_W'(HDR_SWAIT)) begin
                    st_d.swait = prof_data_i;
                end else if (st_q.idx == IDX_W'(HDR_RCNT)) begin
                    st_d.rcnt = (prof_data_i > 32'(MAX_REGS)) ? CR_W'(MAX_REGS)
                                                               : prof_data_i[CR_W-1:0];
                end else begin
                    st_d.tcnt  = (prof_data_i > 32'(MAX_TRIGS)) ? CT_W'(MAX_TRIGS)
                                                                : prof_data_i[CT_W-1:0];
                    st_d.state = S_DLY_DONE;
                    dly_load   = 1'b1;
                    dly_val    = st_q.dwait;
                end
            end
            S_DLY_DONE: begin
                if (dly_exp) begin
                    st_d.state = S_WIRE;
                    st_d.idx   = '0;
                end
            end
            S_WIRE: begin
                addr_c   = PA_W'(WIRE_BASE) + PA_W'(st_q.idx);
                wire_we  = 1'b1;
                st_d.idx = idx_inc;
                if (last_wire) begin
                    st_d.idx = '0;
                    if (st_q.rcnt == '0) begin
                        st_d.state = S_DLY_REG;
                        dly_load   = 1'b1;
                        dly_val    = st_q.rwait;
                    end else begin
                        st_d.state = S_REG_A;
                    end
                end
            end
            S_REG_A: begin
                addr_c     = PA_W'(REG_BASE) + PA_W'({st_q.idx, 1'b0});
                st_d.ra    = prof_data_i;
                st_d.state = S_REG_D;
            end
            S_REG_D: begin
                addr_c     = PA_W'(REG_BASE) + PA_W'({st_q.idx, 1'b1});
                st_d.rd    = prof_data_i;
                st_d.rv    = 1'b1;
                st_d.state = S_REG_W;
            end
            S_REG_W: begin
                if (reg_ready_i) begin
                    st_d.rv = 1'b0;
                    if (last_reg) begin
                        st_d.state = S_DLY_REG;
                        dly_load   = 1'b1;
                        dly_val    = st_q.rwait;
                    end else begin
                        st_d.idx   = idx_inc;
                        st_d.state = S_REG_A;
                    end
                end
            end
            S_DLY_REG: begin
                if (dly_exp) begin
                    st_d.rst   = 1'b0;
                    st_d.state = S_DLY_RST;
                    dly_load   = 1'b1;
                    dly_val    = st_q.swait;
                end
            end
            S_DLY_RST: begin
                if (dly_exp) begin
                    st_d.idx = '0;
                    if (st_q.tcnt == '0) begin
                        st_d.state = S_FIN;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.state = S_TRG_A;
                    end
                end
            end
            S_TRG_A: begin
                addr_c     = PA_W'(TRIG_BASE) + PA_W'({st_q.idx, 1'b0});
                st_d.ta    = prof_data_i;
                st_d.state = S_TRG_D;
            end
            S_TRG_D: begin
                addr_c     = PA_W'(TRIG_BASE) + PA_W'({st_q.idx, 1'b1});
                st_d.tm    = prof_data_i;
                st_d.tv    = 1'b1;
                st_d.state = S_TRG_W;
            end
            S_TRG_W: begin
                if (trig_ready_i) begin
                    st_d.tv = 1'b0;
                    if (last_trg) begin
                        st_d.state = S_FIN;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.idx   = idx_inc;
                        st_d.state = S_TRG_A;
                    end
                end
            end
            default: ;
        endcase

        if (cfg_start_i) begin
            st_d       = '0;
            st_d.state = S_IDLE;
            st_d.rst   = 1'b1;
            wire_clr   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rst <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign prof_addr_o  = addr_c;
    assign tgt_rst_o    = st_q.rst;
    assign reg_valid_o  = st_q.rv;
    assign reg_addr_o   = st_q.ra;
    assign reg_data_o   = st_q.rd;
    assign trig_valid_o = st_q.tv;
    assign trig_addr_o  = st_q.ta;
    assign trig_mask_o  = st_q.tm;
    assign seq_done_o   = st_q.done;

    // R1: a configuration start puts everything back into reset
    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start_i |=> (tgt_rst_o && !seq_done_o && !reg_valid_o && !trig_valid_o));

    // R5: register writes happen only while the target is held in reset
    p_reg_in_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid_o |-> tgt_rst_o);

    // R7: triggers happen only after reset is released
    p_trig_out_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid_o |-> !tgt_rst_o);

    // R11: one transfer outstanding at a time
    p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_valid_o, trig_valid_o}));

    // R11: a stalled register write keeps its contents
    p_reg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid_o && !reg_ready_i && !cfg_start_i) |=>
        (reg_valid_o && $stable(reg_addr_o) && $stable(reg_data_o)));

    // R11: a stalled trigger keeps its contents
    p_trig_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid_o && !trig_ready_i && !cfg_start_i) |=>
        (trig_valid_o && $stable(trig_addr_o) && $stable(trig_mask_o)));

    // R10: completion is sticky and implies a released reset
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done_o && !cfg_start_i) |=> seq_done_o);
    p_done_rel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> !tgt_rst_o);

endmodule

// File: tb/cfg_init_seq_tb.sv
module cfg_init_seq_tb;

    localparam int CPU   = 3;
    localparam int NW    = 32;
    localparam int MR    = 4;
    localparam int MT    = 2;
    localparam logic [31:0] MAGIC_V = 32'h5A17_C0DE;
    localparam int WB    = 8;
    localparam int RB    = WB + NW;
    localparam int TB    = RB + 2 * MR;
    localparam int DEPTH = TB + 2 * MT;
    localparam int AW    = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_start = 1'b0;
    logic            cfg_done = 1'b0;
    logic [AW-1:0]   prof_addr;
    logic [31:0]     prof_data;
    logic            tgt_rst;
    logic [32*NW-1:0] wire_bus;
    logic            reg_valid, reg_ready;
    logic [31:0]     reg_addr, reg_data;
    logic            trig_valid, trig_ready;
    logic [31:0]     trig_addr, trig_mask;
    logic            seq_done;

    logic [31:0]     mem [DEPTH];

    // Expected outputs, maintained by the sequential model
    logic            exp_rst = 1'b1;
    logic            exp_done = 1'b0;
    logic            exp_rv = 1'b0;
    logic [31:0]     exp_ra = '0, exp_rd = '0;
    logic            exp_tv = 1'b0;
    logic [31:0]     exp_ta = '0, exp_tm = '0;
    logic [31:0]     exp_wire [NW];

    int              n_cmp = 0;
    int              n_bad = 0;
    int              cyc   = 0;
    bit              chk_en = 1'b0;
    string           scen  = "R1";
    logic [15:0]     lfsr  = 16'hACE1;

    always #5 clk = ~clk;

    assign prof_data = (int'(prof_addr) < DEPTH) ? mem[prof_addr] : 32'h0;

    cfg_init_seq #(
        .CLKS_PER_US(CPU),
        .NUM_WIRES  (NW),
        .MAX_REGS   (MR),
        .MAX_TRIGS  (MT),
        .MAGIC      (MAGIC_V)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_start_i  (cfg_start),
        .cfg_done_i   (cfg_done),
        .prof_addr_o  (prof_addr),
        .prof_data_i  (prof_data),
        .tgt_rst_o    (tgt_rst),
        .wire_o       (wire_bus),
        .reg_valid_o  (reg_valid),
        .reg_ready_i  (reg_ready),
        .reg_addr_o   (reg_addr),
        .reg_data_o   (reg_data),
        .trig_valid_o (trig_valid),
        .trig_ready_i (trig_ready),
        .trig_addr_o  (trig_addr),
        .trig_mask_o  (trig_mask),
        .seq_done_o   (seq_done)
    );

    // Pseudo-random ready patterns, changed away from the active edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        reg_ready  = lfsr[0];
        trig_ready = lfsr[3];
    end

    task automatic report(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %h expected %h at cycle %0d",
                     tag, scen, what, act, exp, cyc);
        end
    endtask

    // Compare every output on every clock, half a cycle after the edge
    always @(negedge clk) begin
        if (chk_en) begin
            report("R6", "tgt_rst", 32'(tgt_rst), 32'(exp_rst));
            report("R10", "seq_done", 32'(seq_done), 32'(exp_done));
            report("R5", "reg_valid", 32'(reg_valid), 32'(exp_rv));
            report("R7", "trig_valid", 32'(trig_valid), 32'(exp_tv));
            if (exp_rv) begin  // R11: contents held while stalled
                report("R5", "reg_addr", reg_addr, exp_ra);
                report("R5", "reg_data", reg_data, exp_rd);
            end
            if (exp_tv) begin
                report("R7", "trig_addr", trig_addr, exp_ta);
                report("R7", "trig_mask", trig_mask, exp_tm);
            end
            begin
                int bad_j;
                bad_j = -1;
                for (int j = 0; j < NW; j++)
                    if (wire_bus[32*j +: 32] !== exp_wire[j] && bad_j < 0) bad_j = j;
                if (bad_j < 0) report("R3", "wire bank", 32'h0, 32'h0);
                else report("R3", $sformatf("wire[%0d]", bad_j),
                            wire_bus[32*bad_j +: 32], exp_wire[bad_j]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog [%s]: actual %0d cycles expected completion", scen, cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // R4: profile image in the stated layout
    task automatic fill(input logic [31:0] magic, input int dw, input int rw, input int sw,
                        input logic [31:0] rc, input logic [31:0] tc, input int seed);
        for (int a = 0; a < DEPTH; a++) mem[a] = 32'hDEAD_0000 + 32'(a);
        mem[0] = magic;
        mem[1] = 32'(dw);
        mem[2] = 32'(rw);
        mem[3] = 32'(sw);
        mem[4] = rc;
        mem[5] = tc;
        for (int j = 0; j < NW; j++) mem[WB + j] = 32'hA000_0000 + 32'(seed << 16) + 32'(j * 7 + 1);
        for (int i = 0; i < MR; i++) begin
            mem[RB + 2*i]     = 32'h0000_1000 + 32'(i * 4) + 32'(seed);
            mem[RB + 2*i + 1] = 32'hC000_0000 ^ 32'(i * 37 + seed);
        end
        for (int i = 0; i < MT; i++) begin
            mem[TB + 2*i]     = 32'h0000_0040 + 32'(i) + 32'(seed << 8);
            mem[TB + 2*i + 1] = 32'h1 << (i + seed);
        end
    endtask

    // Sequential model of one run: one @(posedge) per clock edge
    task automatic run_scenario();
        int dw, rw, sw, rc, tc;
        dw = int'(mem[1]); rw = int'(mem[2]); sw = int'(mem[3]);
        rc = (mem[4] > 32'(MR)) ? MR : int'(mem[4]);   // R9 clamp
        tc = (mem[5] > 32'(MT)) ? MT : int'(mem[5]);
        @(negedge clk); cfg_start = 1'b1; cfg_done = 1'b0;
        @(posedge clk);                                 // R1: back to reset
        exp_rst = 1'b1; exp_done = 1'b0; exp_rv = 1'b0; exp_tv = 1'b0;
        for (int j = 0; j < NW; j++) exp_wire[j] = '0;
        @(negedge clk); cfg_start = 1'b0; cfg_done = 1'b1;
        @(posedge clk);                                 // edge 0: done seen
        if (mem[0] != MAGIC_V) begin                    // R2
            @(posedge clk);
            exp_rst = 1'b0; exp_done = 1'b1;
        end else begin
            repeat (6) @(posedge clk);                  // header words
            repeat (dw * CPU + 1) @(posedge clk);       // done-wait
            for (int j = 0; j < NW; j++) begin          // R3
                @(posedge clk);
                exp_wire[j] = mem[WB + j];
            end
            for (int i = 0; i < rc; i++) begin          // R5, R8 when rc is 0
                @(posedge clk);
                @(posedge clk);
                exp_rv = 1'b1; exp_ra = mem[RB + 2*i]; exp_rd = mem[RB + 2*i + 1];
                do @(posedge clk); while (!reg_ready);  // R11
                exp_rv = 1'b0;
            end
            repeat (rw * CPU + 1) @(posedge clk);       // R6
            exp_rst = 1'b0;
            repeat (sw * CPU + 1) @(posedge clk);       // R7 reset-wait
            if (tc == 0) exp_done = 1'b1;               // R8, R10
            for (int i = 0; i < tc; i++) begin
                @(posedge clk);
                @(posedge clk);
                exp_tv = 1'b1; exp_ta = mem[TB + 2*i]; exp_tm = mem[TB + 2*i + 1];
                do @(posedge clk); while (!trig_ready);
                exp_tv = 1'b0;
                if (i == tc - 1) exp_done = 1'b1;       // R10
            end
        end
        repeat (8) @(posedge clk);                      // R10: stays complete
    endtask

    initial begin
        for (int j = 0; j < NW; j++) exp_wire[j] = '0;
        for (int a = 0; a < DEPTH; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;                                  // R1: reset state checked
        repeat (3) @(posedge clk);

        scen = "R3 R4 R5 R6 R7 R11";
        fill(MAGIC_V, 2, 1, 3, 32'd3, 32'd2, 1);
        run_scenario();

        scen = "R2";
        fill(32'h1234_5678, 2, 1, 1, 32'd2, 32'd1, 2);
        run_scenario();

        scen = "R8";
        fill(MAGIC_V, 0, 0, 0, 32'd0, 32'd0, 3);
        run_scenario();

        scen = "R9";
        fill(MAGIC_V, 0, 2, 0, 32'hFFFF_FFFF, 32'd7, 4);
        run_scenario();

        scen = "R1 R10";
        fill(MAGIC_V, 1, 0, 2, 32'd1, 32'd1, 5);
        run_scenario();

        @(negedge clk);
        chk_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule